// File: doc/BRIEF.md
# 64-Stage Even-Parity Feedback Shift Register

This block is a 64-stage Fibonacci shift register whose feedback is the even parity of four tapped stages. The sequence is maximal: it visits 2^64 − 1 states before repeating. Because the feedback is even parity, the all-zeros word is a legal member of the sequence. It is therefore the reset value. The single state left out of the sequence is the all-ones word. With even-parity feedback that word maps onto itself.

Each enabled clock advances the register by one stage. The full 64-bit state and a one-bit serial stream are both visible at the outputs. A seed input lets a test or a system place the register at any chosen state. A build-time switch adds a small detector. When the register holds all ones, the detector forces it back to all zeros on the next enabled step. With the switch off, that gating is left out, and all ones stays a fixed point.

Top module: `xnor_lfsr64`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state` becomes all zeros at that edge. Reset has priority over `load_en` and `step_en`.
- R2: When `load_en` is high and `rst` is low at an edge, `state` takes the value of `seed`. Loading has priority over stepping.
- R3: Stage k of the register is `state[k-1]`, so stage 1 is bit 0 and stage 64 is bit 63. On an edge where `step_en` is high, `rst` and `load_en` are low, and no recovery applies, each stage k+1 takes the old value of stage k, and stage 1 takes the feedback bit.
- R4: The feedback bit is 1 when zero, two or four of stages 60, 61, 63 and 64 (bits 59, 60, 62 and 63) are 1, and 0 otherwise. As a result, one step from all zeros gives `state` = 1.
- R5: On an edge where `rst`, `load_en` and `step_en` are all low, `state` keeps its value.
- R6: `serial_out` always equals stage 64, which is `state[63]`.
- R7: When stepping starts from any state other than all ones, the next state is never all ones.
- R8: With `RECOVER_LOCKUP` = 0, an enabled step from all ones leaves `state` at all ones.
- R9: With `RECOVER_LOCKUP` = 1, an enabled step from all ones gives all zeros. Without `step_en`, all ones is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| step_en | input | 1 | Advance the register by one stage |
| load_en | input | 1 | Replace the state with `seed` |
| seed | input | 64 | Value loaded when `load_en` is high |
| state | output | 64 | Full register contents, bit k-1 = stage k |
| serial_out | output | 1 | Stage 64 |

## Verification
The main run starts from reset and steps several thousand times. This long run shows that the tap selection and the parity sense are right, because a wrong tap or an odd-parity feedback moves the sequence away from the arithmetic model within a few dozen steps. A second run starts from a dense loaded seed and drives the enable in an irregular on/off pattern, which separates correct holding from spurious shifting. Seeds placed next to the lockup word, and the lockup word itself, are applied to one instance built with recovery and one built without it. This shows that recovery acts only on all ones, only when stepping, and only in the instance that has it. A reset asserted together with a load, and a load asserted together with a step, expose any fault in the priority order.

// File: rtl/lfsr64_pkg.sv
package lfsr64_pkg;

  localparam int unsigned STAGES   = 64;
  localparam int unsigned NUM_TAPS = 4;

  typedef logic [STAGES-1:0] lfsr_word_t;

  // tapped stages, numbered 1..STAGES (stage k lives in bit k-1)
  localparam int unsigned TAP_STAGE [NUM_TAPS] = '{60, 61, 63, 64};

  // even parity over the tapped stages: 1 when an even count of them is 1
  function automatic logic even_parity_fb(input lfsr_word_t s);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < NUM_TAPS; i++) begin
      acc = acc ^ s[TAP_STAGE[i]-1];
    end
    return acc;
  endfunction

  // one shift: every stage moves up by one, stage 1 takes the feedback
  function automatic lfsr_word_t shift_in(input lfsr_word_t s, input logic fb);
    return {s[STAGES-2:0], fb};
  endfunction

endpackage

// File: rtl/lfsr_tap_parity.sv
module lfsr_tap_parity
  import lfsr64_pkg::*;
(
  input  lfsr_word_t cur_state,
  output logic       fb_bit
);

  always_comb begin
    fb_bit = even_parity_fb(cur_state);
  end

endmodule

// File: rtl/lfsr_lockup_detect.sv
module lfsr_lockup_detect
  import lfsr64_pkg::*;
#(
  parameter bit RECOVER_LOCKUP = 1'b1
) (
  input  lfsr_word_t cur_state,
  output logic       all_ones,
  output logic       recover_hit
);

  assign all_ones = &cur_state;

  generate
    if (RECOVER_LOCKUP) begin : g_recover
      assign recover_hit = all_ones;
    end else begin : g_no_recover
      assign recover_hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
  import lfsr64_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  lfsr_word_t seed,
  input  logic       step_en,
  input  logic       recover_hit,
  input  logic       fb_bit,
  output lfsr_word_t cur_state
);

  lfsr_word_t nxt_state;

  always_comb begin
    nxt_state = cur_state;
    if (load_en) begin
      nxt_state = seed;
    end else if (step_en) begin
      if (recover_hit) nxt_state = '0;
      else             nxt_state = shift_in(cur_state, fb_bit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_state <= '0;
    else     cur_state <= nxt_state;
  end

  // R1
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> cur_state == '0);

  // R2
  a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cur_state == $past(seed));

  // R3: shifted stages and the new stage 1
  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    (!load_en && step_en && !recover_hit) |=>
      (cur_state[STAGES-1:1] == $past(cur_state[STAGES-2:0])) &&
      (cur_state[0] == $past(fb_bit)));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(cur_state));

endmodule

// File: rtl/xnor_lfsr64.sv
module xnor_lfsr64
  import lfsr64_pkg::*;
#(
  parameter bit RECOVER_LOCKUP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              load_en,
  input  logic [STAGES-1:0] seed,
  output logic [STAGES-1:0] state,
  output logic              serial_out
);

  lfsr_word_t state_q;
  logic       fb_bit;
  logic       all_ones;
  logic       recover_hit;

  lfsr_tap_parity u_taps (
    .cur_state (state_q),
    .fb_bit    (fb_bit)
  );

  lfsr_lockup_detect #(.RECOVER_LOCKUP(RECOVER_LOCKUP)) u_lock (
    .cur_state   (state_q),
    .all_ones    (all_ones),
    .recover_hit (recover_hit)
  );

  lfsr_state_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .seed        (seed),
    .step_en     (step_en),
    .recover_hit (recover_hit),
    .fb_bit      (fb_bit),
    .cur_state   (state_q)
  );

  assign state      = state_q;
  assign serial_out = state_q[STAGES-1];

  // R4: one step from all zeros gives 1
  a_r4_zero_step: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0 && step_en && !load_en) |=> state_q == lfsr_word_t'(1));

  // R7: a legal state never steps into the lockup word
  a_r7_no_lockup: assert property (@(posedge clk) disable iff (rst)
    (!all_ones && step_en && !load_en) |=> !all_ones);

  // R8 / R9
  a_r8_r9_lockup_step: assert property (@(posedge clk) disable iff (rst)
    (all_ones && step_en && !load_en) |=>
      (RECOVER_LOCKUP ? (state_q == '0) : (&state_q)));

endmodule

// File: tb/tb_xnor_lfsr64.sv
module tb_xnor_lfsr64;

  logic        clk = 1'b0;
  logic        rst, step_en, load_en;
  logic [63:0] seed;
  logic [63:0] st_r, st_n;
  logic        ser_r, ser_n;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [63:0] exp_r, exp_n;

  always #10 clk = ~clk;

  xnor_lfsr64 #(.RECOVER_LOCKUP(1'b1)) dut (
    .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
    .seed(seed), .state(st_r), .serial_out(ser_r));

  xnor_lfsr64 #(.RECOVER_LOCKUP(1'b0)) dut_nr (
    .clk(clk), .rst(rst), .step_en(step_en), .load_en(load_en),
    .seed(seed), .state(st_n), .serial_out(ser_n));

  // model of the recurrence: tapped stages 60,61,63,64 -> bits 59,60,62,63
  function automatic logic [63:0] model_step(input logic [63:0] s, input bit rec);
    int ones;
    if (rec && s == {64{1'b1}}) return 64'd0;
    ones = $countones({s[59], s[60], s[62], s[63]});
    return {s[62:0], ((ones % 2) == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs, pass one edge, then sample 1 ns later
  task automatic cyc(input logic r, input logic ld, input logic st,
                     input logic [63:0] sd);
    rst = r; load_en = ld; step_en = st; seed = sd;
    @(posedge clk);
    #1;
  endtask

  task automatic cmp_both(input string req);
    check(st_r == exp_r, req, st_r, exp_r);
    check(st_n == exp_n, req, st_n, exp_n);
    check(ser_r == st_r[63] && ser_n == st_n[63], "R6",
          {63'd0, ser_r}, {63'd0, st_r[63]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; load_en = 1'b0; step_en = 1'b0; seed = '0;
    #5;
    // R1: reset state
    cyc(1, 0, 0, '0);
    exp_r = '0; exp_n = '0;
    cmp_both("R1");

    // R4: first step from zero gives 1
    cyc(0, 0, 1, '0);
    exp_r = model_step(exp_r, 1); exp_n = model_step(exp_n, 0);
    check(st_r == 64'd1, "R4", st_r, 64'd1);

    // R3 R4 R7: long sweep from reset
    for (int i = 0; i < 4000; i++) begin
      cyc(0, 0, 1, '0);
      exp_r = model_step(exp_r, 1); exp_n = model_step(exp_n, 0);
      cmp_both("R3");
      check(st_r != {64{1'b1}}, "R7", st_r, '0);
    end

    // R2: load a dense seed
    cyc(0, 1, 0, 64'hDEADBEEF01234567);
    exp_r = 64'hDEADBEEF01234567; exp_n = exp_r;
    cmp_both("R2");

    // R5 R3: irregular enable pattern
    for (int i = 0; i < 3000; i++) begin
      logic en;
      en = ((i % 3) != 1) && ((i % 7) != 5);
      cyc(0, 0, en, '0);
      if (en) begin
        exp_r = model_step(exp_r, 1); exp_n = model_step(exp_n, 0);
      end
      cmp_both(en ? "R3" : "R5");
    end

    // R2: load over step
    cyc(0, 1, 1, 64'h0123456789ABCDEF);
    exp_r = 64'h0123456789ABCDEF; exp_n = exp_r;
    cmp_both("R2");

    // R1: reset over load and step
    cyc(1, 1, 1, 64'hFFFF0000FFFF0000);
    exp_r = '0; exp_n = '0;
    cmp_both("R1");

    // R7: seeds next to lockup
    for (int b = 0; b < 64; b++) begin
      logic [63:0] s;
      s = ~(64'd1 << b);
      cyc(0, 1, 0, s);
      cyc(0, 0, 1, '0);
      exp_r = model_step(s, 1); exp_n = model_step(s, 0);
      cmp_both("R7");
      check(st_r != {64{1'b1}}, "R7", st_r, s);
    end

    // R8 R9: lockup word
    cyc(0, 1, 0, {64{1'b1}});
    cyc(0, 0, 0, '0);
    check(st_r == {64{1'b1}}, "R9 hold without step", st_r, {64{1'b1}});
    check(st_n == {64{1'b1}}, "R5", st_n, {64{1'b1}});
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 1, '0);
      check(st_n == {64{1'b1}}, "R8", st_n, {64{1'b1}});
    end
    check(st_r == 64'd3, "R9", st_r, 64'd3);

    cyc(0, 1, 0, {64{1'b1}});
    cyc(0, 0, 1, '0);
    check(st_r == 64'd0, "R9", st_r, 64'd0);
    check(ser_n == 1'b1, "R6", {63'd0, ser_n}, 64'd1);

    finish_run();
  end

endmodule